// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a master-mode synchronous serial port. Software loads a word into a holding register. The block moves that word into a shift register and sends it out one bit at a time on a serial data line. It also generates the matching serial clock. At the same time it samples an input data line and assembles a received word. When the word is complete, the block places it in a receive holding register.

Four status flags report the state of the port: receive-full, overrun, transmit-empty and bus-idle. Two interrupt lines are formed from these flags, each through its own enable bits. The word length can be set from 5 to 9 bits. The serial clock rate can be set as an even fraction of the system clock. Bits go out least-significant first.

Transmission starts only when both the transmitter and the serial output are enabled. When a new word is already waiting at the end of a word, the next word follows with no gap.

Top module: `csync_xcvr`

## Requirements
- R1: After reset, the outputs are as follows. `flag_tdre`=1, `flag_tbi`=1, `flag_rdrf`=0, `flag_ore`=0, `sck`=1, `sout`=1, `irq_rx`=0 and `irq_tx`=0.
- R2: While idle, `sck` stays high. While shifting, one full `sck` period lasts 2*(`cfg_div`+1) system clocks.
- R3: `sout` changes on the falling edge of `sck`. It carries the low `cfg_len` bits of the written word, least-significant bit first.
- R4: `sin` is sampled on each rising edge of `sck`. After the rising edge that samples the `cfg_len`-th bit, `rdata` holds the word, with the first bit received in bit 0. `flag_rdrf` sets at that point, provided `rx_en`=1.
- R5: A `wr_tdr` pulse clears `flag_tdre`. `flag_tdre` sets again in the cycle in which the word moves to the shift register and shifting begins. `flag_tbi` is 1 exactly when no word is being shifted.
- R6: A word may complete while `flag_rdrf`=1 and no read occurs in that cycle. In that case `flag_ore` sets, the new word is discarded and `rdata` keeps its value.
- R7: A `rd_rdr` pulse clears `flag_rdrf`. A `clr_err` pulse clears `flag_ore`.
- R8: `irq_rx` is 1 exactly when `rie`=1 and at least one of `flag_rdrf` or `flag_ore` is 1.
- R9: `irq_tx` is 1 exactly when (`tie`=1 and `flag_tdre`=1) or (`tbie`=1 and `flag_tbi`=1).
- R10: While `tx_en`=0 or `sout_en`=0, no transfer starts. A written word stays pending with `flag_tdre`=0, and `sck` stays high.
- R11: When `rx_en`=0, a completed word sets neither `flag_rdrf` nor `flag_ore`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 4 | Word length in bits, 5..9 |
| cfg_div | input | 8 | Half-period of `sck` minus one, in system clocks |
| tx_en | input | 1 | Transmitter enable |
| sout_en | input | 1 | Serial output enable |
| rx_en | input | 1 | Receiver enable |
| rie | input | 1 | Receive interrupt enable |
| tie | input | 1 | Transmit-empty interrupt enable |
| tbie | input | 1 | Bus-idle interrupt enable |
| wr_tdr | input | 1 | Write strobe for the transmit holding register |
| wdata | input | 9 | Word to transmit |
| rd_rdr | input | 1 | Read strobe for the receive holding register |
| clr_err | input | 1 | Clears the overrun flag |
| sin | input | 1 | Serial data in |
| rdata | output | 9 | Receive holding register |
| sck | output | 1 | Serial clock, idles high |
| sout | output | 1 | Serial data out, idles high |
| flag_rdrf | output | 1 | Receive register full |
| flag_ore | output | 1 | Overrun error |
| flag_tdre | output | 1 | Transmit register empty |
| flag_tbi | output | 1 | Transmit bus idle |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
Some internal faults show up at the ports within one `sck` period:
- A wrong bit counter makes the word the wrong length.
- A wrong divider count changes the measured `sck` period.
- A wrong shift direction scrambles the word captured from `sout`.

Other faults show up in the flags within one system clock of the strobe or word end that should have set or cleared them. Examples are a flag that misses a set or clear, or an overrun that overwrites `rdata`. A start that ignores the enables shows up as `sck` toggling while it should stay high.

// File: rtl/csync_xcvr.sv
module csync_xcvr #(
  parameter int MAXLEN = 9,
  parameter int DIVW   = 8,
  parameter int LENW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LENW-1:0]   cfg_len,
  input  logic [DIVW-1:0]   cfg_div,
  input  logic              tx_en,
  input  logic              sout_en,
  input  logic              rx_en,
  input  logic              rie,
  input  logic              tie,
  input  logic              tbie,
  input  logic              wr_tdr,
  input  logic [MAXLEN-1:0] wdata,
  input  logic              rd_rdr,
  input  logic              clr_err,
  input  logic              sin,
  output logic [MAXLEN-1:0] rdata,
  output logic              sck,
  output logic              sout,
  output logic              flag_rdrf,
  output logic              flag_ore,
  output logic              flag_tdre,
  output logic              flag_tbi,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [MAXLEN-1:0] tdr, txsh, rxsh, rdr;
  logic              tdre, rdrf, ore, busy, sck_q, sout_q;
  logic [DIVW-1:0]   divcnt;
  logic [LENW-1:0]   bitcnt;

  wire              go_ok   = tx_en & sout_en;
  wire              start   = ~busy & ~tdre & go_ok;
  wire              tick    = busy & (divcnt == '0);
  wire              last    = tick & ~sck_q & (bitcnt == cfg_len - LENW'(1));
  wire              reload  = last & ~tdre & go_ok;
  wire              load    = start | reload;
  wire              done    = last & rx_en;
  wire              full_nr = rdrf & ~rd_rdr;
  wire [MAXLEN-1:0] rx_next = {sin, rxsh[MAXLEN-1:1]};
  wire [MAXLEN-1:0] rx_word = rx_next >> (MAXLEN - int'(cfg_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sck_q  <= 1'b1;
      sout_q <= 1'b1;
      divcnt <= '0;
      bitcnt <= '0;
      txsh   <= '0;
      rxsh   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      txsh   <= tdr;
      divcnt <= cfg_div;
      bitcnt <= '0;
    end else if (busy) begin
      if (divcnt != '0) begin
        divcnt <= divcnt - DIVW'(1);
      end else begin
        divcnt <= cfg_div;
        if (sck_q) begin
          sck_q  <= 1'b0;
          sout_q <= txsh[0];
          txsh   <= txsh >> 1;
        end else begin
          sck_q  <= 1'b1;
          rxsh   <= rx_next;
          bitcnt <= bitcnt + LENW'(1);
          if (last) begin
            bitcnt <= '0;
            if (reload) txsh <= tdr;
            else begin
              busy   <= 1'b0;
              sout_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr  <= '0;
      tdre <= 1'b1;
      rdr  <= '0;
      rdrf <= 1'b0;
      ore  <= 1'b0;
    end else begin
      if (wr_tdr) tdr <= wdata;
      if (wr_tdr)    tdre <= 1'b0;
      else if (load) tdre <= 1'b1;
      if (done && !full_nr) begin
        rdr  <= rx_word;
        rdrf <= 1'b1;
      end else if (rd_rdr) begin
        rdrf <= 1'b0;
      end
      if (done && full_nr) ore <= 1'b1;
      else if (clr_err)    ore <= 1'b0;
    end
  end

  assign rdata     = rdr;
  assign sck       = sck_q;
  assign sout      = sout_q;
  assign flag_rdrf = rdrf;
  assign flag_ore  = ore;
  assign flag_tdre = tdre;
  assign flag_tbi  = ~busy;
  assign irq_rx    = rie & (rdrf | ore);
  assign irq_tx    = (tie & tdre) | (tbie & ~busy);
endmodule

// File: rtl/csync_xcvr_chk.sv
module csync_xcvr_chk #(
  parameter int MAXLEN = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              sout_en,
  input logic              rie,
  input logic              wr_tdr,
  input logic [MAXLEN-1:0] rdata,
  input logic              sck,
  input logic              flag_rdrf,
  input logic              flag_ore,
  input logic              flag_tdre,
  input logic              flag_tbi,
  input logic              irq_rx
);
  AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) flag_tbi |-> sck); // R2
  AST_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) wr_tdr |=> !flag_tdre); // R5
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_ore) |-> $stable(rdata)); // R6
  AST_GATED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (flag_tbi && !(tx_en && sout_en)) |=> flag_tbi); // R10
  AST_RX_IRQ_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rie && $rose(flag_rdrf)) |-> irq_rx); // R8
endmodule

bind csync_xcvr csync_xcvr_chk #(.MAXLEN(MAXLEN)) u_chk (.*);

// File: tb/sim_csync_xcvr.sv
`timescale 1ns/1ps
module sim_csync_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_len = 4'd8;
  logic [7:0] cfg_div = 8'd1;
  logic tx_en = 0, sout_en = 0, rx_en = 0, rie = 0, tie = 0, tbie = 0;
  logic wr_tdr = 0, rd_rdr = 0, clr_err = 0, sin = 0;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic sck, sout, flag_rdrf, flag_ore, flag_tdre, flag_tbi, irq_rx, irq_tx;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csync_xcvr u0 (.*);

  localparam int NV = 4;
  localparam logic [3:0] VLEN [NV] = '{4'd5, 4'd7, 4'd8, 4'd9};
  localparam logic [7:0] VDIV [NV] = '{8'd0, 8'd1, 8'd3, 8'd2};
  localparam logic [8:0] VTX  [NV] = '{9'h015, 9'h05A, 9'h0A5, 9'h1C3};
  localparam logic [8:0] VRX  [NV] = '{9'h00A, 9'h033, 9'h0C3, 9'h12D};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_wr(input logic [8:0] d);
    @(negedge clk); wdata = d; wr_tdr = 1;
    @(negedge clk); wr_tdr = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) rd_rdr = 1; else clr_err = 1;
    @(negedge clk); rd_rdr = 0; clr_err = 0;
  endtask

  task automatic xfer(input logic [8:0] tx, input logic [8:0] rx, input int len,
                      output logic [8:0] got, output int period);
    int i = 0, f1 = -1, f2 = -1;
    logic prev = 1'b1;
    got = '0; period = 0;
    pulse_wr(tx);
    while (i < len) begin
      @(negedge clk);
      if (prev && !sck) begin
        sin = rx[i];
        if (f1 < 0) f1 = cyc; else if (f2 < 0) f2 = cyc;
      end
      if (!prev && sck) begin got[i] = sout; i++; end
      prev = sck;
    end
    if (f2 >= 0) period = f2 - f1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] got, m;
    int per;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tdre", flag_tdre, 1); chk("R1 tbi", flag_tbi, 1);
    chk("R1 rdrf", flag_rdrf, 0); chk("R1 ore", flag_ore, 0);
    chk("R1 sck", sck, 1); chk("R1 sout", sout, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq_rx", irq_rx, 0); chk("R1 irq_tx", irq_tx, 0);

    // R10 gated: no start while tx disabled
    sout_en = 1; rx_en = 1;
    pulse_wr(9'h0AA);
    chk("R5 write clears tdre", flag_tdre, 0);
    repeat (20) @(negedge clk);
    chk("R10 sck idle", sck, 1); chk("R10 tbi", flag_tbi, 1); chk("R10 pending", flag_tdre, 0);
    tx_en = 1;
    @(negedge clk);
    chk("R5 tdre sets at load", flag_tdre, 1); chk("R5 tbi drops", flag_tbi, 0);
    // R9 transmit irq: tie on empty while shifting, tbie alone silent while busy
    tie = 0; tbie = 1;
    @(negedge clk);
    chk("R9 tbie busy", irq_tx, 0);
    tie = 1;
    @(negedge clk);
    chk("R9 tie empty", irq_tx, 1);
    tie = 0;
    wait (flag_tbi); @(negedge clk);
    chk("R9 tbie idle", irq_tx, 1);
    tbie = 0;
    @(negedge clk);
    chk("R9 none", irq_tx, 0);
    pulse(0);
    chk("R7 read clears rdrf", flag_rdrf, 0);

    // table of vectors: R2 R3 R4
    for (int k = 0; k < NV; k++) begin
      cfg_len = VLEN[k]; cfg_div = VDIV[k];
      xfer(VTX[k], VRX[k], int'(VLEN[k]), got, per);
      m = 9'((1 << VLEN[k]) - 1);
      chk("R3 sout word", got, VTX[k] & m);
      chk("R2 sck period", per, 2 * (int'(VDIV[k]) + 1));
      chk("R5 tbi after word", flag_tbi, 1);
      chk("R2 idle high", sck, 1);
      chk("R4 rdrf", flag_rdrf, 1);
      chk("R4 rdata", rdata, VRX[k] & m);
      pulse(0);
      chk("R7 rdrf cleared", flag_rdrf, 0);
    end

    // R6 overrun, R8 irq_rx
    cfg_len = 4'd8; cfg_div = 8'd0; rie = 1;
    xfer(9'h011, 9'h05C, 8, got, per);
    @(negedge clk);
    chk("R8 irq on full", irq_rx, 1);
    xfer(9'h022, 9'h0E7, 8, got, per);
    @(negedge clk);
    chk("R6 ore set", flag_ore, 1);
    chk("R6 rdata kept", rdata, 9'h05C);
    rie = 0;
    @(negedge clk);
    chk("R8 rie off", irq_rx, 0);
    rie = 1;
    pulse(1);
    chk("R7 clr_err", flag_ore, 0);
    chk("R8 still full", irq_rx, 1);
    pulse(0);
    chk("R8 cleared", irq_rx, 0);

    // R11 receiver disabled
    rx_en = 0;
    xfer(9'h0F0, 9'h0FF, 8, got, per);
    @(negedge clk);
    chk("R11 no rdrf", flag_rdrf, 0);
    chk("R11 no ore", flag_ore, 0);
    chk("R11 rdata kept", rdata, 9'h05C);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule